// File: doc/BRIEF.md
# Multiplexed Prescaled Interval Timer

This block measures how long one of four slow signals stays high. All four signals are synchronous to the system clock. A two-bit select picks one of them. A free-running prescaler produces a single-cycle time-base tick once every 2^PRE_W system clocks. With the default 7-bit prescaler at a 40 MHz system clock, that is a 312.5 kHz time base. The master counter is clocked only by the system clock. It advances only on cycles where the tick and the selected signal are both high, so the enable term is the AND of the two and no clock is ever gated.

When the selected signal falls, the accumulated count is copied to the result output and a done strobe fires for one cycle. When the select changes, the counter is cleared and the block enters a discard state. It leaves that state only after the newly chosen signal has been seen low, so a high period that was already running at the moment of the switch is never reported. The counter saturates instead of wrapping.

Top module: `mit_interval_timer`

## Requirements
- R1: While reset is held and on the first cycle after it, `count_out` is 0 and `done` is 0.
- R2: The time-base tick occurs on the 2^PRE_W-th rising clock edge after reset release and on every 2^PRE_W-th edge after that. With PRE_W=7, that is every edge whose index since release is a multiple of 128.
- R3: The counter increases by one only on an edge where both the tick and the selected signal are high. The reported count is the number of tick edges that fell inside the high period.
- R4: A `sel` value of k routes `sig_in[k]` to the measurement. The unselected inputs have no effect on `count_out` or `done`.
- R5: When the selected signal is sampled low after having been sampled high, the next edge loads `count_out` with the count and raises `done` for exactly one cycle.
- R6: `count_out` keeps its value between `done` strobes.
- R7: A change of `sel` clears the counter and suppresses any report until the newly selected signal has been sampled low. A high period in progress at the switch never produces `done`.
- R8: The counter stops at all-ones (2^CNT_W-1) and does not wrap.
- R9: Back-to-back high periods separated by a single low cycle are each reported on their own, each counted from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sig_in | input | NSRC | Candidate signals to be timed |
| sel | input | $clog2(NSRC) | Index of the signal to time |
| count_out | output | CNT_W | Last completed measurement in tick units |
| done | output | 1 | One-cycle strobe when `count_out` is updated |

## Verification
The bench places high periods so that they start exactly on a tick edge, one edge before a tick, and one edge after a tick. A design that used the prescaler's MSB level instead of a single tick, or that was off by one edge, would report counts shifted by one or multiplied by many. It switches the select while both the old and the new source are high. A design that did not discard would raise `done` with a partial count, and one that did not clear would carry stale ticks into the next period. A narrow-counter instance is driven past its limit, which exposes wrapping. Back-to-back periods with a single low cycle between them catch a counter that is not cleared on the report edge.

// File: rtl/mit_pkg.sv
package mit_pkg;
  typedef enum logic {
    MEAS_WAIT_LOW = 1'b0,
    MEAS_ARMED    = 1'b1
  } meas_state_e;
endpackage

// File: rtl/mit_prescaler.sv
module mit_prescaler #(
  parameter int PRE_W = 7
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam logic [PRE_W-1:0] LAST = {PRE_W{1'b1}};

  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_q + PRE_W'(1);
  end

  // one cycle out of 2^PRE_W, on the wrap to zero
  assign tick_o = (pre_q == LAST);
endmodule

// File: rtl/mit_src_select.sv
module mit_src_select #(
  parameter int NSRC  = 4,
  parameter int SEL_W = $clog2(NSRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  sig_in,
  input  logic [SEL_W-1:0] sel,
  output logic             sig_sel_o,
  output logic             sel_chg_o,
  output logic             fall_o
);
  logic [NSRC-1:0]  pick;
  logic [SEL_W-1:0] sel_q;
  logic             sig_prev;

  // AND-OR multiplexer, one leg per source
  for (genvar g = 0; g < NSRC; g++) begin : g_leg
    assign pick[g] = sig_in[g] & (sel == SEL_W'(g));
  end

  assign sig_sel_o = |pick;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q    <= '0;
      sig_prev <= 1'b0;
    end else begin
      sel_q    <= sel;
      sig_prev <= sig_sel_o;
    end
  end

  assign sel_chg_o = (sel != sel_q);
  assign fall_o    = sig_prev & ~sig_sel_o & ~sel_chg_o;
endmodule

// File: rtl/mit_meas_ctrl.sv
module mit_meas_ctrl
  import mit_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             sig_sel_i,
  input  logic             sel_chg_i,
  input  logic             fall_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             discard_o,
  output logic [CNT_W-1:0] count_out,
  output logic             done
);
  meas_state_e      state_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == {CNT_W{1'b1}}) ? v : v + CNT_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= MEAS_WAIT_LOW;
      cnt_q     <= '0;
      count_out <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      if (sel_chg_i) begin
        state_q <= MEAS_WAIT_LOW;
        cnt_q   <= '0;
      end else if (state_q == MEAS_WAIT_LOW) begin
        cnt_q <= '0;
        if (!sig_sel_i) state_q <= MEAS_ARMED;
      end else if (fall_i) begin
        count_out <= cnt_q;
        done      <= 1'b1;
        cnt_q     <= '0;
      end else if (sig_sel_i && tick_i) begin
        cnt_q <= sat_inc(cnt_q);
      end
    end
  end

  assign cnt_o     = cnt_q;
  assign discard_o = (state_q == MEAS_WAIT_LOW);
endmodule

// File: rtl/mit_interval_timer.sv
module mit_interval_timer #(
  parameter int NSRC  = 4,
  parameter int PRE_W = 7,
  parameter int CNT_W = 16,
  localparam int SEL_W = $clog2(NSRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  sig_in,
  input  logic [SEL_W-1:0] sel,
  output logic [CNT_W-1:0] count_out,
  output logic             done
);
  // named internal events, observed by the bound checker
  logic             tick_w;
  logic             sig_sel_w;
  logic             sel_chg_w;
  logic             fall_w;
  logic             discard_w;
  logic [CNT_W-1:0] cnt_w;

  mit_prescaler #(.PRE_W(PRE_W)) i_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_o (tick_w)
  );

  mit_src_select #(.NSRC(NSRC), .SEL_W(SEL_W)) i_sel (
    .clk       (clk),
    .rst_n     (rst_n),
    .sig_in    (sig_in),
    .sel       (sel),
    .sig_sel_o (sig_sel_w),
    .sel_chg_o (sel_chg_w),
    .fall_o    (fall_w)
  );

  mit_meas_ctrl #(.CNT_W(CNT_W)) i_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick_w),
    .sig_sel_i (sig_sel_w),
    .sel_chg_i (sel_chg_w),
    .fall_i    (fall_w),
    .cnt_o     (cnt_w),
    .discard_o (discard_w),
    .count_out (count_out),
    .done      (done)
  );
endmodule

// File: rtl/mit_timer_chk.sv
module mit_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             sig_sel,
  input logic             sel_chg,
  input logic             discard,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] count_out,
  input logic             done
);
  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(count_out));

  // R3
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != $past(cnt) && cnt != '0) |-> ($past(tick) && $past(sig_sel)));

  // R7
  sel_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_chg |=> (discard && cnt == '0 && !done));

  // R7
  done_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !$past(discard));

  // R8
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '1 && tick && sig_sel && !discard && !sel_chg) |=> (cnt == '1));
endmodule

bind mit_interval_timer mit_timer_chk #(.CNT_W(CNT_W)) i_timer_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick      (tick_w),
  .sig_sel   (sig_sel_w),
  .sel_chg   (sel_chg_w),
  .discard   (discard_w),
  .cnt       (cnt_w),
  .count_out (count_out),
  .done      (done)
);

// File: tb/test_mit_interval_timer.sv
`timescale 1ns/1ps
module test_mit_interval_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  sig_in = '0;
  logic [1:0]  sel = '0;
  logic [15:0] count_out;
  logic        done;
  logic [3:0]  count_s;
  logic        done_s;

  int checks = 0;
  int errors = 0;
  int ecnt = 0;
  int ndone = 0;

  always #5 clk = ~clk;

  mit_interval_timer i_mit_interval_timer (
    .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .sel(sel),
    .count_out(count_out), .done(done));

  // narrow instance: tick every 4 edges, 4-bit counter
  mit_interval_timer #(.PRE_W(2), .CNT_W(4)) i_sat (
    .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .sel(sel),
    .count_out(count_s), .done(done_s));

  always @(posedge clk) begin
    if (!rst_n) ecnt <= 0;
    else        ecnt <= ecnt + 1;
  end

  always @(negedge clk) if (rst_n && done) ndone++;

  typedef struct packed {
    logic [1:0]  vsel;
    logic [6:0]  ph;
    logic [15:0] len;
    logic [3:0]  others;
    logic [15:0] exp;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{2'd0, 7'd1,   16'd127,  4'b1110, 16'd0},
    '{2'd1, 7'd0,   16'd1,    4'b1101, 16'd1},
    '{2'd2, 7'd1,   16'd128,  4'b1011, 16'd1},
    '{2'd3, 7'd127, 16'd2,    4'b0111, 16'd1},
    '{2'd0, 7'd5,   16'd1000, 4'b0110, 16'd7},
    '{2'd2, 7'd0,   16'd256,  4'b1001, 16'd2},
    '{2'd1, 7'd127, 16'd1,    4'b0000, 16'd0},
    '{2'd3, 7'd64,  16'd640,  4'b1111, 16'd5}
  };

  function automatic int exp_cnt(int a, int len, int period, int maxv);
    int c;
    c = (a + len - 1) / period - (a - 1) / period;
    return (c > maxv) ? maxv : c;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_phase(input int ph);
    do @(negedge clk); while (((ecnt + 1) % 128) != ph);
  endtask

  task automatic change_sel(input logic [1:0] s);
    @(negedge clk);
    sig_in = '0;
    sel = s;
    repeat (3) @(negedge clk);
  endtask

  // raise the selected source for len edges, check the report
  task automatic run_pulse(input logic [1:0] s, input int ph, input int len,
                           input logic [3:0] others, input int exp, input string tag);
    int a;
    if (s != sel) change_sel(s);
    wait_phase(ph);
    sig_in = (others & ~(4'b1 << s)) | (4'b1 << s);
    a = ecnt + 1;
    repeat (len) @(negedge clk);
    sig_in[s] = 1'b0;
    @(negedge clk);
    chk(done === 1'b1, {tag, " R5 done"}, int'(done), 1);
    chk(count_out === 16'(exp), {tag, " R3 count"}, int'(count_out), exp);
    chk(exp_cnt(a, len, 128, 65535) == exp, {tag, " R2 table"}, exp_cnt(a, len, 128, 65535), exp);
    chk(count_s === 4'(exp_cnt(a, len, 4, 15)), {tag, " R8 narrow"}, int'(count_s), exp_cnt(a, len, 4, 15));
    @(negedge clk);
    chk(done === 1'b0, {tag, " R5 one cycle"}, int'(done), 0);
    sig_in = '0;
  endtask

  initial begin
    #(200000 * 10);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", ecnt);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n0;
    int c0;
    int a1;
    int a2;
    repeat (4) @(negedge clk);
    chk(count_out === 16'd0, "R1 reset count", int'(count_out), 0);
    chk(done === 1'b0, "R1 reset done", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(count_out === 16'd0 && done === 1'b0, "R1 after release", int'(count_out), 0);

    // table of vectors (R2 R3 R4 R5 R8)
    for (int i = 0; i < 8; i++)
      run_pulse(VEC[i].vsel, int'(VEC[i].ph), int'(VEC[i].len), VEC[i].others,
                int'(VEC[i].exp), $sformatf("vec%0d", i));

    // R7: switch to a source that is already high, partial period dropped
    change_sel(2'd0);
    n0 = ndone;
    c0 = int'(count_out);
    sig_in = 4'b0011;
    repeat (300) @(negedge clk);
    sel = 2'd1;
    repeat (200) @(negedge clk);
    sig_in[1] = 1'b0;
    repeat (50) @(negedge clk);
    sig_in[0] = 1'b0;
    repeat (10) @(negedge clk);
    chk(ndone == n0, "R7 no done for partial period", ndone, n0);
    chk(int'(count_out) == c0, "R7 result untouched", int'(count_out), c0);
    run_pulse(2'd1, 0, 128, 4'b0000, 1, "R7 clean restart");

    // R9: two periods, one low cycle apart
    change_sel(2'd2);
    wait_phase(10);
    sig_in[2] = 1'b1;
    a1 = ecnt + 1;
    repeat (300) @(negedge clk);
    sig_in[2] = 1'b0;
    @(negedge clk);
    sig_in[2] = 1'b1;
    a2 = ecnt + 1;
    chk(done === 1'b1 && count_out === 16'(exp_cnt(a1, 300, 128, 65535)),
        "R9 first period", int'(count_out), exp_cnt(a1, 300, 128, 65535));
    repeat (200) @(negedge clk);
    sig_in[2] = 1'b0;
    @(negedge clk);
    chk(done === 1'b1 && count_out === 16'(exp_cnt(a2, 200, 128, 65535)),
        "R9 second period", int'(count_out), exp_cnt(a2, 200, 128, 65535));

    // R6 / R4: unselected sources toggle, result held
    @(negedge clk);
    n0 = ndone;
    c0 = int'(count_out);
    for (int k = 0; k < 400; k++) begin
      sig_in = {~sig_in[3], ~sig_in[1], ~sig_in[1] ^ sig_in[3], 1'b0} & 4'b1011;
      @(negedge clk);
    end
    sig_in = '0;
    repeat (5) @(negedge clk);
    chk(ndone == n0, "R4 unselected toggles give no done", ndone, n0);
    chk(int'(count_out) == c0, "R6 result held", int'(count_out), c0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule